// File: doc/BRIEF.md
# Extended CRTC Register File

This block holds the indexed register set of a CRT controller. A host bus reaches it through two byte ports. One port selects an index. The other port reads or writes the register at that index. A monochrome/colour select input can move the port pair between the 0x3Bx and 0x3Dx groups. The file also holds extended registers, and it decodes them into outputs for the rest of the display path:
- banked-aperture read and write offsets,
- a pixel-depth code,
- overflow additions for the horizontal and vertical timing values,
- start-address and row-offset extensions,
- an access-mode nibble,
- two bit-banged display-data-channel lines.

Reads of some extended indices return live status: the current display line and the state of the data-channel lines. A write that changes the value of a timing-relevant register raises a one-cycle pulse, which tells the timing generator to recompute its values.

The register file stores indices 0 up to NREG-1. With the default, that is 0x00 to 0x3F. A write to an index at or above NREG is dropped, and a read there returns zero.

Top module: `crtc_ext_regs`

## Requirements
- R1: After reset, every register, the index, every decoded output and the recalculate pulse are zero.
- R2: When `port_color` is 0, any host address in the 0x3B0–0x3BF or 0x3D0–0x3DF group is XORed with 0x60 before decode. The pair 0x3B4/0x3B5 then acts as index/data, and 0x3D4/0x3D5 decode to nothing and read 0. When `port_color` is 1, 0x3D4/0x3D5 act and 0x3B4/0x3B5 read 0.
- R3: A write to the index port loads the index, and a read of the index port returns it. A read of the data port returns the stored register, unless R6, R7 or R8 applies. Reads are combinational, and writes take effect at the clock edge.
- R4: While register 0x11 bit 7 is 1, data writes to indices 0x00–0x06 leave them unchanged. A data write to index 0x07 changes only bit 4 and keeps bits 7:5 and 3:0.
- R5: `rd_bank_off` equals register 0x1E and `wr_bank_off` equals register 0x1D. Each is shifted left by 15 bits when `chained` is 1 and by 13 bits when it is 0.
- R6: A read of index 0x28 returns the stored value ANDed with 0x3F. `pix_depth` is bits 1:0 of that register, where 1 means 8, 2 means 16 and 3 means 32 bits per pixel.
- R7: A read of index 0x34 returns `disp_line[7:0]`. A read of index 0x35 returns `disp_line[10:8]` in bits 2:0, with zeros above.
- R8: `ddc_sda` is bit 4 and `ddc_scl` is bit 5 of register 0x3F. A read of index 0x3E returns SDA in bit 3, SCL in bit 2, and 0 in every other bit.
- R9: Register 0x25 bits 0, 1, 2 and 3 add 0x400 to `vtotal_add`, `vdend_add`, `vblank_add` and `vsync_add`. Bit 4 adds 0x100 to `htotal_add`. Register 0x2D bit 0 adds 0x100 to `hdisp_add`. Each output is 0 when its bit is clear.
- R10: `start_ext` is register 0x19 bits 4:0 placed at bit 16. `row_ext` is register 0x19 bits 7:5 placed at bit 8.
- R11: `access_mode` is the low nibble of register 0x38.
- R12: `recalc` is 1 for exactly the one cycle after a data write stores a value that differs from the old one, and only when the index is outside 0x0E–0x10. A write that is blocked, or that stores the same value, gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_color | input | 1 | Colour port group select; 0 applies the 0x60 alias |
| chained | input | 1 | Chained memory mode; selects the bank shift |
| disp_line | input | 11 | Current display line |
| io_addr | input | 16 | Host I/O address |
| io_wdata | input | 8 | Host write data |
| io_wr | input | 1 | Host write strobe |
| io_rdata | output | 8 | Host read data (combinational) |
| rd_bank_off | output | 23 | Read bank byte offset |
| wr_bank_off | output | 23 | Write bank byte offset |
| pix_depth | output | 2 | Pixel depth code |
| vtotal_add | output | 11 | Vertical total addition |
| vdend_add | output | 11 | Display end addition |
| vblank_add | output | 11 | Vertical blank start addition |
| vsync_add | output | 11 | Vertical sync start addition |
| htotal_add | output | 9 | Horizontal total addition |
| hdisp_add | output | 9 | Horizontal display addition |
| start_ext | output | 21 | Start address extension |
| row_ext | output | 11 | Row offset extension |
| access_mode | output | 4 | Access-mode nibble |
| ddc_sda | output | 1 | Data-channel SDA drive |
| ddc_scl | output | 1 | Data-channel SCL drive |
| recalc | output | 1 | One-cycle timing recalculate pulse |

## Verification
Read data is combinational. The bench settles the address and samples `io_rdata` in the same low clock phase, with no edge in between. Decoded outputs such as the bank offsets, overflow additions and data-channel lines change at the edge that takes the write. The bench reads them at the falling edge after that write edge. The recalculate pulse is registered from the same write edge and lasts one cycle, so the bench captures it at that same falling edge. A check at the next falling edge confirms the pulse has dropped.

// File: rtl/crtc_ext_regs.sv
module crtc_ext_regs #(
  parameter int NREG   = 64,
  parameter int LINE_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_color,
  input  logic              chained,
  input  logic [LINE_W-1:0] disp_line,
  input  logic [15:0]       io_addr,
  input  logic [7:0]        io_wdata,
  input  logic              io_wr,
  output logic [7:0]        io_rdata,
  output logic [22:0]       rd_bank_off,
  output logic [22:0]       wr_bank_off,
  output logic [1:0]        pix_depth,
  output logic [10:0]       vtotal_add,
  output logic [10:0]       vdend_add,
  output logic [10:0]       vblank_add,
  output logic [10:0]       vsync_add,
  output logic [8:0]        htotal_add,
  output logic [8:0]        hdisp_add,
  output logic [20:0]       start_ext,
  output logic [10:0]       row_ext,
  output logic [3:0]        access_mode,
  output logic              ddc_sda,
  output logic              ddc_scl,
  output logic              recalc
);
  localparam int IW = $clog2(NREG);

  logic [NREG-1:0][7:0] regs;
  logic [7:0]           idx_q;

  wire        alias_grp = (io_addr[15:4] == 12'h03D) || (io_addr[15:4] == 12'h03B);
  wire [15:0] pa        = (!port_color && alias_grp) ? (io_addr ^ 16'h0060) : io_addr;
  wire        idx_sel   = (pa == 16'h03D4);
  wire        dat_sel   = (pa == 16'h03D5);

  wire        in_range  = ({24'd0, idx_q} < NREG);
  wire [7:0]  cur       = in_range ? regs[idx_q[IW-1:0]] : 8'h00;
  wire        lock      = regs[8'h11][7];
  wire        blocked   = lock && (idx_q < 8'h07);
  wire [7:0]  newv      = (lock && idx_q == 8'h07) ? ((cur & 8'hEF) | (io_wdata & 8'h10)) : io_wdata;
  wire        do_store  = io_wr && dat_sel && in_range && !blocked;
  wire        quiet_idx = (idx_q >= 8'h0E) && (idx_q <= 8'h10);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      regs   <= '0;
      idx_q  <= 8'h00;
      recalc <= 1'b0;
    end else begin
      if (io_wr && idx_sel) idx_q <= io_wdata;
      if (do_store) regs[idx_q[IW-1:0]] <= newv;
      recalc <= do_store && (newv != cur) && !quiet_idx;
    end
  end

  always_comb begin
    io_rdata = 8'h00;
    if (idx_sel) io_rdata = idx_q;
    else if (dat_sel) begin
      case (idx_q)
        8'h28:   io_rdata = cur & 8'h3F;
        8'h34:   io_rdata = disp_line[7:0];
        8'h35:   io_rdata = {5'd0, disp_line[10:8]};
        8'h3E:   io_rdata = {4'd0, ddc_sda, ddc_scl, 2'd0};
        default: io_rdata = cur;
      endcase
    end
  end

  wire [7:0] r19 = regs[8'h19];
  wire [7:0] r25 = regs[8'h25];

  assign rd_bank_off = chained ? {regs[8'h1E], 15'd0} : {2'd0, regs[8'h1E], 13'd0};
  assign wr_bank_off = chained ? {regs[8'h1D], 15'd0} : {2'd0, regs[8'h1D], 13'd0};
  assign pix_depth   = regs[8'h28][1:0];
  assign vtotal_add  = {r25[0], 10'd0};
  assign vdend_add   = {r25[1], 10'd0};
  assign vblank_add  = {r25[2], 10'd0};
  assign vsync_add   = {r25[3], 10'd0};
  assign htotal_add  = {r25[4], 8'd0};
  assign hdisp_add   = {regs[8'h2D][0], 8'd0};
  assign start_ext   = {r19[4:0], 16'd0};
  assign row_ext     = {r19[7:5], 8'd0};
  assign access_mode = regs[8'h38][3:0];
  assign ddc_sda     = regs[8'h3F][4];
  assign ddc_scl     = regs[8'h3F][5];

  assert_idx_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && idx_sel) |=> (idx_q == $past(io_wdata)));

  assert_lock_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && dat_sel && !idx_sel && lock && idx_q < 8'h07) |=> $stable(regs));

  assert_ddc_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && dat_sel && idx_q == 8'h3F) |=> (ddc_sda == $past(io_wdata[4]) && ddc_scl == $past(io_wdata[5])));

  assert_recalc_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
    recalc |-> $past(io_wr && dat_sel && !quiet_idx));

  assert_recalc_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (recalc && !io_wr) |=> !recalc);
endmodule

// File: tb/sim_crtc_ext_regs.sv
module sim_crtc_ext_regs;
  logic        clk = 0, rst_n = 0, port_color = 1, chained = 0;
  logic [10:0] disp_line = 11'h5A3;
  logic [15:0] io_addr = 0;
  logic [7:0]  io_wdata = 0;
  logic        io_wr = 0;
  logic [7:0]  io_rdata;
  logic [22:0] rd_bank_off, wr_bank_off;
  logic [1:0]  pix_depth;
  logic [10:0] vtotal_add, vdend_add, vblank_add, vsync_add, row_ext;
  logic [8:0]  htotal_add, hdisp_add;
  logic [20:0] start_ext;
  logic [3:0]  access_mode;
  logic        ddc_sda, ddc_scl, recalc;

  int checks = 0, failures = 0;
  logic last_recalc;
  logic [7:0] model [64];
  bit done = 0;

  crtc_ext_regs u0 (.*);

  always #5 clk = ~clk;

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1;
    @(negedge clk); last_recalc = recalc; io_wr = 0; io_addr = 16'h0000;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk); io_addr = a; #1 d = io_rdata; io_addr = 16'h0000;
  endtask

  task automatic reg_wr(input logic [7:0] i, input logic [7:0] d);
    wr(16'h03D4, i); wr(16'h03D5, d);
  endtask

  task automatic reg_rd(input logic [7:0] i, output logic [7:0] d);
    wr(16'h03D4, i); rd(16'h03D5, d);
  endtask

  function automatic logic [7:0] exp_read(input int i);
    case (i)
      8'h28:   return model[i] & 8'h3F;
      8'h34:   return disp_line[7:0];
      8'h35:   return {5'd0, disp_line[10:8]};
      8'h3E:   return {4'd0, model[8'h3F][4], model[8'h3F][5], 2'd0};
      default: return model[i];
    endcase
  endfunction

  initial begin
    repeat (1000000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    for (int i = 0; i < 64; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 outputs", {rd_bank_off, wr_bank_off, pix_depth, access_mode, ddc_sda, ddc_scl, recalc}, 0);
    chk("R1 timing", {vtotal_add, vdend_add, vblank_add, vsync_add, htotal_add, hdisp_add, start_ext, row_ext}, 0);
    rst_n = 1;
    rd(16'h03D4, d); chk("R1 R3 index", d, 0);
    rd(16'h03D5, d); chk("R1 reg0", d, 0);

    // R3 R12 sweep of every index
    for (int i = 0; i < 64; i++) begin
      logic [7:0] v;
      logic exp_pulse;
      v = 8'(i) ^ 8'h35;
      wr(16'h03D4, 8'(i));
      rd(16'h03D4, d); chk("R3 index readback", d, i);
      exp_pulse = (v != model[i]) && !(i >= 8'h0E && i <= 8'h10);
      wr(16'h03D5, v);
      model[i] = v;
      chk("R12 pulse on change", last_recalc, exp_pulse);
      @(negedge clk); chk("R12 one cycle", recalc, 0);
      rd(16'h03D5, d); chk("R3 R6 R7 R8 readback", d, exp_read(i));
      wr(16'h03D5, v);
      chk("R12 same value no pulse", last_recalc, 0);
    end

    // R7 live line
    disp_line = 11'h2C7;
    reg_rd(8'h34, d); chk("R7 line low", d, 8'hC7);
    reg_rd(8'h35, d); chk("R7 line high", d, 8'h02);

    // R5 banks
    reg_wr(8'h1E, 8'h12); reg_wr(8'h1D, 8'hAB);
    chained = 0; @(negedge clk);
    chk("R5 rd bank plain", rd_bank_off, 23'h12 << 13);
    chk("R5 wr bank plain", wr_bank_off, 23'hAB << 13);
    chained = 1; @(negedge clk);
    chk("R5 rd bank chained", rd_bank_off, 23'h12 << 15);
    chk("R5 wr bank chained", wr_bank_off, 23'hAB << 15);

    // R6 depth
    for (int v = 0; v < 4; v++) begin
      reg_wr(8'h28, 8'hFC | 8'(v));
      chk("R6 depth", pix_depth, v);
      rd(16'h03D5, d); chk("R6 masked read", d, 8'h3C | v);
    end

    // R8 data channel lines
    for (int v = 0; v < 4; v++) begin
      reg_wr(8'h3F, 8'(v) << 4);
      chk("R8 sda", ddc_sda, v & 1);
      chk("R8 scl", ddc_scl, (v >> 1) & 1);
      reg_rd(8'h3E, d); chk("R8 status read", d, ((v & 1) << 3) | (((v >> 1) & 1) << 2));
    end

    // R9 overflow sweep
    for (int v = 0; v < 32; v++) begin
      reg_wr(8'h25, 8'(v));
      chk("R9 vertical", {vtotal_add, vdend_add, vblank_add, vsync_add},
          {11'((v & 1) * 'h400), 11'(((v >> 1) & 1) * 'h400), 11'(((v >> 2) & 1) * 'h400), 11'(((v >> 3) & 1) * 'h400)});
      chk("R9 htotal", htotal_add, ((v >> 4) & 1) * 'h100);
    end
    reg_wr(8'h2D, 8'hFE); chk("R9 hdisp off", hdisp_add, 0);
    reg_wr(8'h2D, 8'h01); chk("R9 hdisp on", hdisp_add, 'h100);

    // R10 start/row extension
    for (int v = 0; v < 256; v += 37) begin
      reg_wr(8'h19, 8'(v));
      chk("R10 start", start_ext, (v & 'h1F) << 16);
      chk("R10 row", row_ext, ((v >> 5) & 7) << 8);
    end

    // R11 access mode
    reg_wr(8'h38, 8'hF7); chk("R11 mode", access_mode, 7);
    reg_wr(8'h38, 8'h0C); chk("R11 mode", access_mode, 'hC);

    // R4 lock
    reg_wr(8'h03, 8'h11); reg_wr(8'h07, 8'h6A);
    reg_wr(8'h11, 8'h80);
    reg_wr(8'h03, 8'h77);
    chk("R4 blocked no pulse", last_recalc, 0);
    rd(16'h03D5, d); chk("R4 reg3 held", d, 8'h11);
    reg_wr(8'h00, 8'hFF);
    rd(16'h03D5, d); chk("R4 reg0 held", d, model[0]);
    reg_wr(8'h07, 8'h95);
    chk("R4 R12 reg7 bit4 pulse", last_recalc, 1);
    rd(16'h03D5, d); chk("R4 reg7 bit4 only", d, 8'h7A);
    reg_wr(8'h11, 8'h00);
    reg_wr(8'h03, 8'h77);
    rd(16'h03D5, d); chk("R4 unlocked", d, 8'h77);

    // R2 aliasing
    port_color = 0;
    wr(16'h03B4, 8'h0C); wr(16'h03B5, 8'h5C);
    rd(16'h03B5, d); chk("R2 mono data", d, 8'h5C);
    rd(16'h03B4, d); chk("R2 mono index", d, 8'h0C);
    rd(16'h03D5, d); chk("R2 colour port dead", d, 0);
    port_color = 1;
    rd(16'h03D5, d); chk("R2 colour data", d, 8'h5C);
    rd(16'h03B5, d); chk("R2 mono port dead", d, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule